// File: doc/BRIEF.md
# Byte-Level Two-Wire Bus Master Transmitter

This block drives a two-wire serial bus as a master, one byte frame at a time, for a host that talks to it through a handful of strobes and status outputs. The host loads a byte, requests a start condition, and the engine sends the target address with a write direction bit. It then samples the target's acknowledge and stops with the clock held low and the interrupt flag raised. While the flag is up the bus is frozen. The host then loads the next byte, asks for a stop, or does nothing. If it does nothing, the following frame is read from the target rather than written.

In receive frames the interrupt comes once the eighth data bit is in, before the acknowledge clock. The host can then decide whether the block acknowledges the byte or not. A lost-arbitration input ends master operation at once from any active state. Both lines are open drain: the block only ever pulls them low through enable outputs and reads the data line back through a separate input. The serial clock period is four quarter phases, each QDIV system clocks long.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset both line enables are off, the interrupt flag is 0 and the mode field is 2'b00.
- R2: A start request makes the data line fall while the clock line is high, and the mode field becomes master transmit (2'b11) and stays with bit 1 set until the transfer ends.
- R3: The first frame after a start sends bits 7..1 of the loaded byte MSB first, and the eighth bit on the wire is 0 whatever bit 0 of the loaded byte was.
- R4: Apart from the start and stop conditions, the data line never changes while the clock line is high.
- R5: In a transmit frame the block releases the data line for the ninth clock. It records ack_o = 1 when the target held the line low and 0 when it did not. The interrupt is raised only after that ninth clock has gone low again.
- R6: While the interrupt flag is set during master operation the clock line is held low and no clock edge occurs.
- R7: A byte loaded while a transmit interrupt is pending is sent MSB first in the next frame, in mode 2'b11.
- R8: If no byte is loaded before a transmit interrupt is cleared, the next frame is a receive frame. The mode becomes 2'b10, the data line is released for eight clocks and the received byte appears on rd_data. The interrupt is raised after the eighth clock and before the ninth.
- R9: On the ninth clock of a receive frame the block pulls the data line low if host_ack was 1 when the interrupt was cleared, and releases it if host_ack was 0.
- R10: A stop request taken at the end of a frame produces a stop condition (data rises while the clock is high). The mode returns to 2'b00 and no interrupt is raised.
- R11: An asserted arb_lost during master operation releases both lines on the next cycle, sets the mode to 2'b00 and raises the interrupt. It wins over an interrupt clear in the same cycle, and no new start follows.
- R12: A byte load in the same cycle as an interrupt clear counts as loaded, and the next frame is a transmit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Load strobe for the byte register |
| wr_data | input | 8 | Byte to load |
| sta_set | input | 1 | Request a start condition |
| sto_set | input | 1 | Request a stop condition |
| irq_clr | input | 1 | Clear the interrupt flag |
| host_ack | input | 1 | Acknowledge choice for receive frames (1 = acknowledge) |
| arb_lost | input | 1 | Lost-arbitration indication |
| rd_data | output | 8 | Byte register (last loaded or last received byte) |
| ack_o | output | 1 | Acknowledge status of the last frame |
| irq_o | output | 1 | Byte-complete interrupt flag |
| mode_o | output | 2 | 00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit |
| scl_oe | output | 1 | Pull the clock line low |
| sda_oe | output | 1 | Pull the data line low |
| sda_in | input | 1 | Data line level |

## Verification
Two pairs of host actions can land in the same cycle. The bench presents each pair on one clock edge. A byte load together with an interrupt clear must still give a transmit frame carrying that byte. An arbitration loss together with an interrupt clear must leave the flag set, the mode at 2'b00 and the bus idle. A behavioural bus monitor with a modelled target decides the outcome. It rebuilds every bit, start and stop from the line levels and judges them against the bytes and acknowledge choices that the bench itself selected.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       sta_set,
  input  logic       sto_set,
  input  logic       irq_clr,
  input  logic       host_ack,
  input  logic       arb_lost,
  output logic [7:0] rd_data,
  output logic       ack_o,
  output logic       irq_o,
  output logic [1:0] mode_o,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);

  localparam int CW = (QDIV > 2) ? $clog2(QDIV) : 1;
  localparam logic [1:0] M_IDLE = 2'b00;
  localparam logic [1:0] M_MRX  = 2'b10;
  localparam logic [1:0] M_MTX  = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_ACK, S_HOLD, S_STOP} st_t;

  st_t         st;
  logic [1:0]  qc;
  logic [2:0]  bc;
  logic [CW-1:0] cnt;
  logic [7:0]  sh, dreg;
  logic        ack_q, irq_q, sta_q, sto_q, wr_pend;
  logic [1:0]  mode_q;

  wire tick = (cnt == CW'(QDIV - 1));
  wire tx   = mode_q[0];

  assign rd_data = dreg;
  assign ack_o   = ack_q;
  assign irq_o   = irq_q;
  assign mode_o  = mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; qc <= '0; bc <= '0; sh <= '0; dreg <= '0;
      ack_q <= 1'b0; irq_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      wr_pend <= 1'b0; mode_q <= M_IDLE;
    end else begin
      if (wr_en) begin
        dreg    <= wr_data;
        wr_pend <= 1'b1;
      end
      if (sta_set) sta_q <= 1'b1;
      if (sto_set) sto_q <= 1'b1;
      if (irq_clr) irq_q <= 1'b0;

      if (tick) begin
        qc <= qc + 2'd1;
        unique case (st)
          S_IDLE: begin
            qc <= '0;
            if (sta_q) begin
              st     <= S_START;
              mode_q <= M_MTX;
            end
          end
          S_START: if (qc == 2'd3) begin
            st      <= S_BIT;
            bc      <= '0;
            sh      <= {dreg[7:1], 1'b0};
            wr_pend <= 1'b0;
            sta_q   <= 1'b0;
          end
          S_BIT: begin
            if (qc == 2'd2 && !tx) sh <= {sh[6:0], sda_in};
            if (qc == 2'd3) begin
              bc <= bc + 3'd1;
              if (tx) sh <= {sh[6:0], 1'b0};
              if (bc == 3'd7) begin
                if (tx) st <= S_ACK;
                else begin
                  st    <= S_HOLD;
                  irq_q <= 1'b1;
                  dreg  <= sh;
                end
              end
            end
          end
          S_ACK: begin
            if (qc == 2'd2 && tx) ack_q <= ~sda_in;
            if (qc == 2'd3) begin
              if (tx) begin
                st    <= S_HOLD;
                irq_q <= 1'b1;
              end else if (sto_q) st <= S_STOP;
              else begin
                st <= S_BIT;
                bc <= '0;
              end
            end
          end
          S_HOLD: begin
            qc <= '0;
            if (!irq_q) begin
              if (!tx) begin
                st    <= S_ACK;
                ack_q <= host_ack;
              end else if (sto_q) st <= S_STOP;
              else begin
                st <= S_BIT;
                bc <= '0;
                if (wr_pend) begin
                  sh      <= dreg;
                  wr_pend <= 1'b0;
                end else mode_q <= M_MRX;
              end
            end
          end
          S_STOP: if (qc == 2'd3) begin
            st     <= S_IDLE;
            mode_q <= M_IDLE;
            sto_q  <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end

      if (arb_lost && st != S_IDLE) begin
        st     <= S_IDLE;
        qc     <= '0;
        mode_q <= M_IDLE;
        irq_q  <= 1'b1;
        sta_q  <= 1'b0;
        sto_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    unique case (st)
      S_IDLE:  ;
      S_START: begin scl_oe = (qc == 2'd3); sda_oe = (qc != 2'd0); end
      S_BIT:   begin scl_oe = (qc == 2'd0 || qc == 2'd3); sda_oe = tx & ~sh[7]; end
      S_ACK:   begin scl_oe = (qc == 2'd0 || qc == 2'd3); sda_oe = ~tx & ack_q; end
      S_HOLD:  scl_oe = 1'b1;
      S_STOP:  begin scl_oe = (qc == 2'd0); sda_oe = (qc < 2'd2); end
      default: ;
    endcase
  end

  assert_hold_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && st != S_IDLE) |-> scl_oe) else $error("R6 clock not held");

  assert_arb_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost && st != S_IDLE) |=> (!scl_oe && !sda_oe && irq_o && mode_o == M_IDLE))
    else $error("R11 arbitration exit");

  assert_sda_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && !$past(arb_lost) && st != S_START && st != S_STOP)
      |-> $stable(sda_oe)) else $error("R4 data moved with clock high");

  assert_master_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT || st == S_ACK || st == S_HOLD) |-> mode_o[1]) else $error("R2 mode");

  assert_tx_irq_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && mode_o == M_MTX) |-> $past(st) == S_ACK) else $error("R5 irq timing");

  assert_rx_irq_before_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o) && mode_o == M_MRX) |-> $past(st) == S_BIT) else $error("R8 irq timing");

  assert_stop_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_STOP && st == S_IDLE && !$past(arb_lost)) |-> (mode_o == M_IDLE && !irq_o))
    else $error("R10 stop exit");

endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, sta_set = 0, sto_set = 0, irq_clr = 0, host_ack = 0, arb_lost = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ack_o, irq_o, scl_oe, sda_oe;
  logic [1:0] mode_o;
  logic slv_pull = 1'b0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | slv_pull);

  always #2 clk = ~clk;

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .sta_set(sta_set),
    .sto_set(sto_set), .irq_clr(irq_clr), .host_ack(host_ack), .arb_lost(arb_lost),
    .rd_data(rd_data), .ack_o(ack_o), .irq_o(irq_o), .mode_o(mode_o),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor and target model
  logic pscl = 1, psda = 1, pirq = 0;
  int rises = 0, starts = 0, stops = 0;
  logic [7:0] mbyte = '0, last_byte = '0;
  logic last9 = 1'b1;
  bit slv_ack = 1, slv_rx = 0;
  logic [7:0] slv_tx = '0;

  always @(negedge clk) if (rst_n) begin
    if (pscl && scl && psda && !sda) begin starts++; rises = 0; end
    if (pscl && scl && !psda && sda) stops++;
    if (!pscl && scl) begin
      if (rises < 8) mbyte = {mbyte[6:0], sda};
      else begin last_byte = mbyte; last9 = sda; end
      rises++;
    end
    if (pscl && !scl && rises == 9) rises = 0;
    if (!scl) begin
      if (rises == 8)                slv_pull = !slv_rx && slv_ack;
      else if (rises < 8 && slv_rx)  slv_pull = ~slv_tx[7 - rises];
      else                           slv_pull = 1'b0;
    end
    if (!pirq && irq_o) begin
      if (mode_o == 2'b11) chk(rises == 0, "R5 tx irq after ninth clock", rises, 0);
      else if (mode_o == 2'b10) chk(rises == 8, "R8 rx irq before ninth clock", rises, 8);
    end
    if (irq_o && mode_o[1]) chk(!scl, "R6 clock low while flag set", scl, 0);
    pscl = scl; psda = sda; pirq = irq_o;
  end

  task automatic host(input bit wr, input logic [7:0] d, input bit sta, input bit sto,
                      input bit clr, input bit arb);
    @(negedge clk);
    wr_en = wr; wr_data = d; sta_set = sta; sto_set = sto; irq_clr = clr; arb_lost = arb;
    @(negedge clk);
    wr_en = 0; sta_set = 0; sto_set = 0; irq_clr = 0; arb_lost = 0;
  endtask

  task automatic wait_irq(input string req);
    for (int i = 0; i < 4000; i++) begin
      if (irq_o) break;
      @(negedge clk);
    end
    chk(irq_o, req, irq_o, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl && sda, "R1 lines released", {scl, sda}, 3);
    chk(!irq_o, "R1 flag clear", irq_o, 0);
    chk(mode_o == 2'b00, "R1 mode", mode_o, 0);

    // address frame, target acknowledges
    slv_ack = 1; slv_rx = 0;
    host(1, 8'hA5, 0, 0, 0, 0);
    host(0, 8'h00, 1, 0, 0, 0);
    wait_irq("R2 address frame irq");
    chk(starts == 1, "R2 start seen", starts, 1);
    chk(mode_o == 2'b11, "R2 master transmit mode", mode_o, 3);
    chk(last_byte == 8'hA4, "R3 address with write bit", last_byte, 8'hA4);
    chk(ack_o == 1'b1, "R5 ack recorded", ack_o, 1);

    begin
      int r0 = rises;
      repeat (60) @(negedge clk);
      chk(rises == r0 && !scl, "R6 bus frozen", rises, r0);
    end

    // load and clear in one cycle, target refuses
    slv_ack = 0;
    host(1, 8'h3C, 0, 0, 1, 0);
    wait_irq("R12 data frame irq");
    chk(last_byte == 8'h3C, "R7 data byte on wire", last_byte, 8'h3C);
    chk(ack_o == 1'b0, "R5 nack recorded", ack_o, 0);
    chk(mode_o == 2'b11, "R12 still transmitting", mode_o, 3);

    // no load: receive
    slv_rx = 1; slv_tx = 8'h96;
    host(0, 8'h00, 0, 0, 1, 0);
    wait_irq("R8 receive irq");
    chk(mode_o == 2'b10, "R8 master receive mode", mode_o, 2);
    chk(rd_data == 8'h96, "R8 received byte", rd_data, 8'h96);

    slv_tx = 8'h5B; host_ack = 1;
    host(0, 8'h00, 0, 0, 1, 0);
    wait_irq("R8 second receive irq");
    chk(rd_data == 8'h5B, "R8 second received byte", rd_data, 8'h5B);
    chk(last9 == 1'b0, "R9 acknowledge driven", last9, 0);

    host_ack = 0; slv_rx = 0;
    host(0, 8'h00, 0, 1, 1, 0);
    for (int i = 0; i < 400; i++) begin
      if (mode_o == 2'b00) break;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    chk(last9 == 1'b1, "R9 no acknowledge", last9, 1);
    chk(stops == 1, "R10 stop seen", stops, 1);
    chk(mode_o == 2'b00 && !irq_o, "R10 idle after stop", {mode_o, irq_o}, 0);
    chk(scl && sda, "R10 lines released", {scl, sda}, 3);

    // arbitration loss with a clear in the same cycle
    slv_ack = 1;
    host(1, 8'h40, 0, 0, 0, 0);
    host(0, 8'h00, 1, 0, 0, 0);
    wait_irq("R11 address irq");
    host(0, 8'h00, 0, 0, 1, 1);
    chk(irq_o, "R11 flag wins over clear", irq_o, 1);
    chk(mode_o == 2'b00, "R11 left master mode", mode_o, 0);
    chk(scl && sda, "R11 lines released", {scl, sda}, 3);
    host(0, 8'h00, 0, 0, 1, 0);
    repeat (100) @(negedge clk);
    chk(!irq_o && mode_o == 2'b00 && scl && sda, "R11 stays idle", {irq_o, mode_o}, 0);
    chk(starts == 2 && stops == 1, "R4 only intended start and stop edges", starts * 16 + stops, 33);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule